// File: doc/BRIEF.md
# Duration-Qualified Dual Interrupt Controller

The block watches two external request pins and raises a CPU interrupt only for requests that are both clean and long enough. Each channel first brings its pin into the clock domain through two flops. A fixed glitch filter then rejects any level change that does not hold for `FILT_CYCLES` clocks, which is sized so the window falls between 80 and 120 µs at the system clock. A polarity bit then turns the clean level into an "active" request.

While its run bit is set, a channel counts prescaler ticks for as long as the request stays active. It latches a pending flag once the count reaches its 6-bit duration setting. The count starts again from zero whenever the request drops. A single request sets the pending flag at most once, until that request is released.

Pending flags that are enabled drive one interrupt line, and channel 1 takes precedence. The CPU clears a flag with an acknowledge pulse that names the channel. Software also sees each pin's synchronized level directly, with neither the filter nor the polarity applied.

Top module: `dual_irq_qual`

## Requirements
- R1: `pin_level[i]` equals `pin_i[i]` as sampled two clock edges earlier; neither the glitch filter nor the polarity bit affects it.
- R2: A synchronized pin level that differs from the filtered level for fewer than `FILT_CYCLES` consecutive clocks never changes the filtered level, so it cannot start or extend a duration count.
- R3: The polarity bit of a channel selects the active level: 0 means a filtered high is a request, 1 means a filtered low is a request.
- R4: With the run bit at 1, `pending[i]` sets on the N-th prescaler tick (one tick every `TICK_DIV` clocks, free running from reset) of continuously active request, where N is the channel's 6-bit duration setting; a setting of 0 behaves as 1.
- R5: Whenever the request goes inactive, the channel's tick count returns to zero, so separate shorter bursts never add up.
- R6: After `pending[i]` has been set, it is not set again until the request has gone inactive, even if the flag is acknowledged while the request is still held.
- R7: While the run bit of a channel is 0, its count stays at zero and its pending flag is cleared on the clock edge after the bit reads 0.
- R8: An acknowledge (`ack_valid`=1 with `ack_chan`=0 for channel 1, 1 for channel 2) clears that channel's pending flag on the next edge; a set that occurs on the same edge wins.
- R9: `irq` is high when any channel has both pending and enable set; `irq_chan` is 0 when channel 1 is enabled and pending, otherwise 1, and is meaningful only while `irq` is high.
- R10: Register writes occur on an edge with `wr_en`=1: address 0 sets the channel 1 duration from `wr_data[5:0]`, address 1 sets the channel 2 duration, address 2 sets run1 (bit 0), run2 (bit 1), pol1 (bit 2) and pol2 (bit 3), and address 3 sets en1 (bit 0) and en2 (bit 1).
- R11: After a synchronous active-low reset, all settings, counts and flags are zero, so `pending`, `irq` and `pin_level` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 2 | External request pins, bit 0 is channel 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 6 | Register write data |
| ack_valid | input | 1 | CPU acknowledge pulse |
| ack_chan | input | 1 | Channel being acknowledged (0 = channel 1) |
| pin_level | output | 2 | Synchronized raw pin levels |
| pending | output | 2 | Pending flags per channel |
| irq | output | 1 | Interrupt request to the CPU |
| irq_chan | output | 1 | Channel presented on `irq` |

## Verification
The duration qualifier is exercised with several pin patterns. A glitch shorter than the filter window shows whether the filter really rejects noise. A single long hold shows the exact tick on which pending sets. Two medium bursts with a gap between them must not add up. A hold that continues through an acknowledge must not set pending a second time. The same patterns are also run with inverted polarity, with the run bit off, with the enables masked, and with both channels pending at once. Those runs separate the effects of polarity, the run gate, the enable gate and the channel-1 precedence. A behavioural model compares `pending`, `irq`, `irq_chan` and `pin_level` on every clock, which pins each flag change to its exact cycle.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int NCH   = 2;
  localparam int DUR_W = 6;
  localparam int REG_W = 6;

  typedef logic [DUR_W-1:0] dur_t;

  typedef enum logic [1:0] {
    A_DUR1 = 2'd0,
    A_DUR2 = 2'd1,
    A_CTRL = 2'd2,
    A_ENAB = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dirq_filter.sv
module dirq_filter #(
  parameter int FILT_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level_sync,
  output logic level_clean
);
  localparam int FW = $clog2(FILT_CYCLES) + 1;
  localparam logic [FW-1:0] LAST = FW'(FILT_CYCLES - 1);

  logic       meta_q, sync_q, clean_q;
  logic [FW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clean_q <= 1'b0;
      run_cnt <= '0;
    end else if (sync_q == clean_q) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      clean_q <= sync_q;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign level_sync  = sync_q;
  assign level_clean = clean_q;

  // R2: the clean level only moves to a value the synchronized pin held
  a_r2_clean_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clean_q) |-> ($past(sync_q) == clean_q) && ($past(run_cnt) == LAST));
endmodule

// File: rtl/dirq_qual.sv
module dirq_qual
  import dirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic active,
  input  logic tick,
  input  dur_t setting,
  input  logic ack,
  output logic pend
);
  dur_t ticks_q;
  logic fired_q, pend_q;
  logic reach, set_now;

  assign reach   = ({1'b0, ticks_q} + 7'd1) >= {1'b0, setting};
  assign set_now = run && active && !fired_q && tick && reach;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ticks_q <= '0;
      fired_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (!run) begin
      ticks_q <= '0;
      fired_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (!active) begin
        ticks_q <= '0;
        fired_q <= 1'b0;
      end else if (!fired_q && tick) begin
        if (reach) begin
          ticks_q <= '0;
          fired_q <= 1'b1;
        end else begin
          ticks_q <= ticks_q + 1'b1;
        end
      end
      if (set_now)  pend_q <= 1'b1;
      else if (ack) pend_q <= 1'b0;
    end
  end

  assign pend = pend_q;

  // R7: run off clears the flag on the following edge
  a_r7_run_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pend_q);
  // R4 / R6: a new flag only appears from an active, running request
  a_r6_set_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(active) && $past(run) && $past(tick));
  // R8: acknowledge without a concurrent set clears the flag
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_now) |=> !pend_q);
endmodule

// File: rtl/dual_irq_qual.sv
module dual_irq_qual
  import dirq_pkg::*;
#(
  parameter int FILT_CYCLES = 10000,
  parameter int TICK_DIV    = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   pin_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ack_valid,
  input  logic             ack_chan,
  output logic [NCH-1:0]   pin_level,
  output logic [NCH-1:0]   pending,
  output logic             irq,
  output logic             irq_chan
);
  localparam int TW = $clog2(TICK_DIV) + 1;
  localparam logic [TW-1:0] TLAST = TW'(TICK_DIV - 1);

  dur_t           dur_q [NCH];
  logic [NCH-1:0] run_q, pol_q, en_q;
  logic [TW-1:0]  div_q;
  logic           tick;
  logic [NCH-1:0] clean, pend_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dur_q[0] <= '0;
      dur_q[1] <= '0;
      run_q    <= '0;
      pol_q    <= '0;
      en_q     <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_DUR1: dur_q[0] <= wr_data[DUR_W-1:0];
        A_DUR2: dur_q[1] <= wr_data[DUR_W-1:0];
        A_CTRL: begin
          run_q <= wr_data[1:0];
          pol_q <= wr_data[3:2];
        end
        default: en_q <= wr_data[1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             div_q <= '0;
    else if (div_q == TLAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end
  assign tick = (div_q == TLAST);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dirq_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin        (pin_i[i]),
      .level_sync (pin_level[i]),
      .level_clean(clean[i])
    );
    dirq_qual u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q[i]),
      .active (clean[i] ^ pol_q[i]),
      .tick   (tick),
      .setting(dur_q[i]),
      .ack    (ack_valid && (ack_chan == 1'(i))),
      .pend   (pending[i])
    );
  end

  assign pend_en  = pending & en_q;
  assign irq      = |pend_en;
  assign irq_chan = !pend_en[0];

  // R9: nothing reaches the CPU line from a masked channel
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
  // R9: channel 1 presented whenever it is enabled and pending
  a_r9_ch1_first: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_chan) |-> !(pending[0] && en_q[0]));
endmodule

// File: tb/sim_dual_irq_qual.sv
module sim_dual_irq_qual;
  localparam int F = 8;
  localparam int T = 4;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] pin_i = '0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic       ack_valid = 0;
  logic       ack_chan = 0;
  logic [1:0] pin_level, pending;
  logic       irq, irq_chan;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_irq_qual #(.FILT_CYCLES(F), .TICK_DIV(T)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack_valid(ack_valid), .ack_chan(ack_chan),
    .pin_level(pin_level), .pending(pending), .irq(irq), .irq_chan(irq_chan)
  );

  // behavioural reference
  int m_s1[2], m_s2[2], m_f[2], m_fc[2], m_cnt[2], m_fired[2], m_pend[2];
  int m_dur[2], m_run[2], m_pol[2], m_en[2];
  int m_tc;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_fc[i] = 0; m_cnt[i] = 0;
        m_fired[i] = 0; m_pend[i] = 0; m_dur[i] = 0; m_run[i] = 0;
        m_pol[i] = 0; m_en[i] = 0;
      end
      m_tc = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        int act, need, setp;
        act  = m_f[i] ^ m_pol[i];
        need = (m_dur[i] == 0) ? 1 : m_dur[i];
        setp = 0;
        if (m_run[i] == 0) begin
          m_cnt[i] = 0; m_fired[i] = 0; m_pend[i] = 0;
        end else begin
          if (act == 0) begin
            m_cnt[i] = 0; m_fired[i] = 0;
          end else if (m_fired[i] == 0 && m_tc == T-1) begin
            if (m_cnt[i] + 1 >= need) begin
              m_cnt[i] = 0; m_fired[i] = 1; setp = 1;
            end else m_cnt[i] = m_cnt[i] + 1;
          end
          if (setp != 0) m_pend[i] = 1;
          else if (ack_valid && int'(ack_chan) == i) m_pend[i] = 0;
        end
        if (m_s2[i] == m_f[i]) m_fc[i] = 0;
        else if (m_fc[i] == F-1) begin m_f[i] = m_s2[i]; m_fc[i] = 0; end
        else m_fc[i] = m_fc[i] + 1;
        m_s2[i] = m_s1[i];
        m_s1[i] = int'(pin_i[i]);
      end
      m_tc = (m_tc == T-1) ? 0 : m_tc + 1;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_dur[0] = int'(wr_data);
          2'd1: m_dur[1] = int'(wr_data);
          2'd2: begin
            m_run[0] = int'(wr_data[0]); m_run[1] = int'(wr_data[1]);
            m_pol[0] = int'(wr_data[2]); m_pol[1] = int'(wr_data[3]);
          end
          default: begin m_en[0] = int'(wr_data[0]); m_en[1] = int'(wr_data[1]); end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int e_irq, e_ch;
      e_irq = (m_pend[0] & m_en[0]) | (m_pend[1] & m_en[1]);
      e_ch  = (m_pend[0] & m_en[0]) ? 0 : 1;
      chk("R4 model pending", int'(pending), m_pend[1]*2 + m_pend[0]);
      chk("R1 model pin_level", int'(pin_level), m_s2[1]*2 + m_s2[0]);
      chk("R9 model irq", int'(irq), e_irq);
      if (e_irq != 0) chk("R9 model irq_chan", int'(irq_chan), e_ch);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ack(input logic ch);
    @(negedge clk);
    ack_valid = 1; ack_chan = ch;
    @(negedge clk);
    ack_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(4);
    // R11 reset state
    chk("R11 pending after reset", int'(pending), 0);
    chk("R11 irq after reset", int'(irq), 0);
    chk("R11 pin_level after reset", int'(pin_level), 0);
    rst_n = 1;
    // R10 register setup
    wr(2'd0, 6'd3); wr(2'd1, 6'd3); wr(2'd2, 6'b000011); wr(2'd3, 6'b000011);

    // R1 raw readback of a short glitch, R2 glitch rejected
    pin_i = 2'b01;
    cyc(2);
    chk("R1 raw level visible", int'(pin_level), 1);
    cyc(3);
    pin_i = 2'b00;
    cyc(40);
    chk("R2 glitch gives no pending", int'(pending), 0);

    // R4 long hold: not too early, then set
    pin_i[0] = 1;
    cyc(15);
    chk("R4 not before duration", int'(pending[0]), 0);
    cyc(45);
    chk("R4 pending after duration", int'(pending[0]), 1);
    chk("R9 irq for channel 1", int'(irq), 1);
    chk("R9 irq_chan channel 1", int'(irq_chan), 0);

    // R8 acknowledge, R6 no re-arm while still held
    ack(1'b0);
    chk("R8 ack clears channel 1", int'(pending[0]), 0);
    cyc(60);
    chk("R6 no second set while held", int'(pending[0]), 0);
    pin_i[0] = 0;
    cyc(20);

    // R5 bursts do not accumulate (20 ticks = 80 clocks)
    wr(2'd0, 6'd20);
    pin_i[0] = 1; cyc(50); pin_i[0] = 0; cyc(20);
    pin_i[0] = 1; cyc(50); pin_i[0] = 0; cyc(20);
    chk("R5 bursts do not add", int'(pending[0]), 0);
    pin_i[0] = 1; cyc(120);
    chk("R4 long setting reached", int'(pending[0]), 1);
    pin_i[0] = 0; ack(1'b0); cyc(20);

    // R3 inverted polarity: low pin is a request
    wr(2'd0, 6'd2);
    wr(2'd2, 6'b000111);
    cyc(40);
    chk("R3 low-active request sets", int'(pending[0]), 1);
    pin_i[0] = 1; ack(1'b0); cyc(20);
    chk("R3 high is idle when inverted", int'(pending[0]), 0);
    wr(2'd2, 6'b000011);
    pin_i[0] = 0; cyc(20);

    // R9 masking and precedence
    wr(2'd3, 6'b000010);
    pin_i[0] = 1; cyc(60);
    chk("R9 masked channel 1 pending", int'(pending[0]), 1);
    chk("R9 masked channel gives no irq", int'(irq), 0);
    pin_i[1] = 1; cyc(60);
    wr(2'd3, 6'b000011);
    chk("R9 both pending", int'(pending), 3);
    chk("R9 channel 1 presented first", int'(irq_chan), 0);
    ack(1'b0);
    chk("R9 channel 2 after ack", int'(irq_chan), 1);
    chk("R9 irq still high", int'(irq), 1);

    // R7 run off clears and stops counting
    wr(2'd2, 6'b000001);
    cyc(1);
    chk("R7 run off clears pending", int'(pending[1]), 0);
    cyc(100);
    chk("R7 no count while stopped", int'(pending[1]), 0);
    wr(2'd2, 6'b000011);
    cyc(5);
    chk("R7 restart needs full duration", int'(pending[1]), 0);
    cyc(30);
    chk("R7 pending after restart", int'(pending[1]), 1);
    ack(1'b1);
    chk("R8 ack clears channel 2", int'(pending[1]), 0);
    pin_i = 2'b00;
    cyc(20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule